// File: doc/BRIEF.md
# Transmit Descriptor Chain Validator

This block sits in front of a transmit DMA engine and inspects each descriptor before any buffer is fetched. A descriptor reaches it as three 32-bit words over a valid/ready handshake, always in this order: a control word whose two low bits hold the frame-position code, a size word whose upper half holds the buffer byte count, and a word holding the buffer start address. Once the third word is taken, the block either passes the descriptor on as start/end flags, byte count and address with a one-cycle strobe, or it declares a fault.

A running "frame open" flag records whether the last accepted descriptor left a frame unfinished. Position codes must respect that flag. Byte counts must be nonzero and no larger than 0xFFE0. Addresses must be word aligned. Any violation drops the input ready signal for good and holds a fault flag with a reason code until reset. Nonzero bits in the reserved lower half of the size word do not stop the descriptor; they only raise a warning pulse.

Top module: `txdesc_seq_checker`

## Requirements
- R1: After reset in_ready is 1, out_valid, len_warn and fault are 0, fault_code is 0 and no frame is open.
- R2: Words are taken as control, size, address on cycles where in_valid and in_ready are both 1; one cycle after the address word is taken a legal descriptor appears with out_start = control bit 1, out_end = control bit 0, out_len = size bits 31:16 and out_addr = the address word.
- R3: Size bits 15:0 never reach out_len; if any of them is 1, len_warn pulses for one cycle one cycle after the address word, and the descriptor is still accepted when otherwise legal.
- R4: A byte count of zero sets fault with fault_code 1.
- R5: A byte count above 0xFFE0 sets fault with fault_code 2; exactly 0xFFE0 is accepted.
- R6: An address with either of bits 1:0 set sets fault with fault_code 3.
- R7: Position codes are 10 start, 00 middle, 01 last, 11 whole frame; 00 and 01 are legal only while a frame is open, 10 and 11 only while none is open, and any other case sets fault with fault_code 4 (so 11 followed by 01 faults).
- R8: After reset no frame is open, so a first descriptor coded 00 or 01 faults with fault_code 4.
- R9: When several checks fail, the reported code follows the priority zero count, oversize, misalignment, then position order.
- R10: Once fault is 1 it stays 1 with an unchanged fault_code, in_ready stays 0 and out_valid stays 0 until reset; reset clears it.
- R11: out_valid is a single-cycle pulse per accepted descriptor and is never 1 together with fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor word present |
| in_ready | output | 1 | Block can take a word (0 while faulted) |
| in_data | input | 32 | Descriptor word |
| out_valid | output | 1 | Accepted descriptor strobe |
| out_start | output | 1 | Descriptor opens a frame |
| out_end | output | 1 | Descriptor closes a frame |
| out_len | output | 16 | Buffer byte count |
| out_addr | output | 32 | Buffer start address |
| len_warn | output | 1 | Reserved size bits were nonzero |
| fault | output | 1 | Sticky fault flag |
| fault_code | output | 3 | 0 none, 1 zero count, 2 oversize, 3 misaligned, 4 position order |

## Verification
The bench goes after the count boundary, where 0xFFE0 must pass and 0xFFE1 must fault, so an off-by-one comparator either rejects a legal maximum buffer or lets an oversize one through. It drives whole frames followed by a trailing 01, and a 00 straight after reset, which a design that forgets or misupdates the frame-open flag would accept as legal. Descriptors with several faults at once check the reason priority, where a wrong order would show up as the wrong fault_code. After every fault, words keep arriving so that a fault that was not sticky would show a ready or strobe coming back.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int POS_W  = 2;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ZERO_LEN = 3'd1,
    ERR_OVERSIZE = 3'd2,
    ERR_MISALIGN = 3'd3,
    ERR_SEQUENCE = 3'd4
  } err_code_e;

  typedef enum logic [1:0] {
    W_CTRL = 2'd0,
    W_SIZE = 2'd1,
    W_ADDR = 2'd2
  } word_sel_e;

  // byte count lives in the upper half of the size word
  function automatic logic [LEN_W-1:0] size_count(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: LEN_W];
  endfunction

  function automatic logic size_rsvd_set(input logic [WORD_W-1:0] w);
    return |w[WORD_W-LEN_W-1:0];
  endfunction

  function automatic logic addr_aligned(input logic [WORD_W-1:0] a, input int lsb);
    logic [WORD_W-1:0] mask;
    mask = (32'd1 << lsb) - 32'd1;
    return (a & mask) == '0;
  endfunction

  // a code with bit 1 set begins a frame; legal only when none is open
  function automatic logic pos_legal(input logic [POS_W-1:0] pos, input logic open);
    return pos[1] == !open;
  endfunction

  // frame remains open after a descriptor unless it carries the end bit
  function automatic logic open_after(input logic [POS_W-1:0] pos);
    return !pos[0];
  endfunction

endpackage

// File: rtl/txdesc_word_collect.sv
module txdesc_word_collect
  import txdesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              accept_en,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              last_fire,
  output logic [POS_W-1:0]  pos_q,
  output logic [WORD_W-1:0] size_q
);

  word_sel_e sel_q;
  logic      fire;

  assign in_ready  = accept_en;
  assign fire      = in_valid && in_ready;
  assign last_fire = fire && (sel_q == W_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= W_CTRL;
      pos_q  <= '0;
      size_q <= '0;
    end else if (fire) begin
      case (sel_q)
        W_CTRL: begin
          pos_q <= in_data[POS_W-1:0];
          sel_q <= W_SIZE;
        end
        W_SIZE: begin
          size_q <= in_data;
          sel_q  <= W_ADDR;
        end
        default: sel_q <= W_CTRL;
      endcase
    end
  end

endmodule

// File: rtl/txdesc_validate.sv
module txdesc_validate
  import txdesc_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_LEN    = 16'hFFE0,
  parameter int               ALIGN_BITS = 2
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] size_word,
  input  logic [WORD_W-1:0] addr,
  input  logic              frame_open,
  output err_code_e         err,
  output logic              warn
);

  logic [LEN_W-1:0] count;

  assign count = size_count(size_word);
  assign warn  = size_rsvd_set(size_word);

  always_comb begin
    if (count == '0)                        err = ERR_ZERO_LEN;
    else if (count > MAX_LEN)               err = ERR_OVERSIZE;
    else if (!addr_aligned(addr, ALIGN_BITS)) err = ERR_MISALIGN;
    else if (!pos_legal(pos, frame_open))   err = ERR_SEQUENCE;
    else                                    err = ERR_NONE;
  end

endmodule

// File: rtl/txdesc_fault_track.sv
module txdesc_fault_track
  import txdesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_fire,
  input  err_code_e         err,
  input  logic              warn,
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] size_word,
  input  logic [WORD_W-1:0] addr,
  output logic              frame_open,
  output logic              accept_en,
  output logic              out_valid,
  output logic              out_start,
  output logic              out_end,
  output logic [LEN_W-1:0]  out_len,
  output logic [WORD_W-1:0] out_addr,
  output logic              len_warn,
  output logic              fault,
  output err_code_e         fault_code
);

  assign accept_en = !fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_open <= 1'b0;
      out_valid  <= 1'b0;
      out_start  <= 1'b0;
      out_end    <= 1'b0;
      out_len    <= '0;
      out_addr   <= '0;
      len_warn   <= 1'b0;
      fault      <= 1'b0;
      fault_code <= ERR_NONE;
    end else begin
      out_valid <= 1'b0;
      len_warn  <= 1'b0;
      if (desc_fire) begin
        len_warn <= warn;
        if (err == ERR_NONE) begin
          out_valid  <= 1'b1;
          out_start  <= pos[1];
          out_end    <= pos[0];
          out_len    <= size_count(size_word);
          out_addr   <= addr;
          frame_open <= open_after(pos);
        end else begin
          fault      <= 1'b1;
          fault_code <= err;
        end
      end
    end
  end

endmodule

// File: rtl/txdesc_seq_checker.sv
module txdesc_seq_checker
  import txdesc_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_LEN    = 16'hFFE0,
  parameter int               ALIGN_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic        out_start,
  output logic        out_end,
  output logic [15:0] out_len,
  output logic [31:0] out_addr,
  output logic        len_warn,
  output logic        fault,
  output logic [2:0]  fault_code
);

  // named internal events, visible to the bound checker
  logic              desc_fire;
  logic              accept_en;
  logic              frame_open;
  logic              rsvd_warn;
  logic [POS_W-1:0]  pos_q;
  logic [WORD_W-1:0] size_q;
  err_code_e         desc_err;
  err_code_e         code_q;

  txdesc_word_collect collect_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept_en (accept_en),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .last_fire (desc_fire),
    .pos_q     (pos_q),
    .size_q    (size_q)
  );

  txdesc_validate #(
    .MAX_LEN    (MAX_LEN),
    .ALIGN_BITS (ALIGN_BITS)
  ) validate_i (
    .pos        (pos_q),
    .size_word  (size_q),
    .addr       (in_data),
    .frame_open (frame_open),
    .err        (desc_err),
    .warn       (rsvd_warn)
  );

  txdesc_fault_track track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_fire  (desc_fire),
    .err        (desc_err),
    .warn       (rsvd_warn),
    .pos        (pos_q),
    .size_word  (size_q),
    .addr       (in_data),
    .frame_open (frame_open),
    .accept_en  (accept_en),
    .out_valid  (out_valid),
    .out_start  (out_start),
    .out_end    (out_end),
    .out_len    (out_len),
    .out_addr   (out_addr),
    .len_warn   (len_warn),
    .fault      (fault),
    .fault_code (code_q)
  );

  assign fault_code = code_q;

endmodule

// File: rtl/txdesc_seq_checker_sva.sv
module txdesc_seq_checker_sva
  import txdesc_pkg::*;
#(
  parameter logic [LEN_W-1:0] MAX_LEN    = 16'hFFE0,
  parameter int               ALIGN_BITS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        desc_fire,
  input logic        out_valid,
  input logic        out_start,
  input logic        out_end,
  input logic [15:0] out_len,
  input logic [31:0] out_addr,
  input logic        fault,
  input logic [2:0]  fault_code
);

  // independent frame-open shadow built only from the output stream
  logic shadow_open;
  always_ff @(posedge clk) begin
    if (!rst_n)         shadow_open <= 1'b0;
    else if (out_valid) shadow_open <= !out_end;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !fault && fault_code == 3'd0));

  assert_fire_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_fire |=> (out_valid || fault));

  assert_len_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0 && out_len <= MAX_LEN));

  assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> addr_aligned(out_addr, ALIGN_BITS));

  assert_pos_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_start == !shadow_open));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(fault_code)));

  assert_no_ready_in_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !in_ready);

  assert_fault_has_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_code != 3'd0));

  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_strobe_not_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fault);

endmodule

bind txdesc_seq_checker txdesc_seq_checker_sva #(
  .MAX_LEN    (MAX_LEN),
  .ALIGN_BITS (ALIGN_BITS)
) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .desc_fire  (desc_fire),
  .out_valid  (out_valid),
  .out_start  (out_start),
  .out_end    (out_end),
  .out_len    (out_len),
  .out_addr   (out_addr),
  .fault      (fault),
  .fault_code (fault_code)
);

// File: tb/txdesc_seq_checker_tb_top.sv
`timescale 1ns/1ps
module txdesc_seq_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_start;
  logic        out_end;
  logic [15:0] out_len;
  logic [31:0] out_addr;
  logic        len_warn;
  logic        fault;
  logic [2:0]  fault_code;

  int checks = 0;
  int errors = 0;
  bit m_open;
  bit m_fault;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txdesc_seq_checker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_start(out_start),
    .out_end(out_end), .out_len(out_len), .out_addr(out_addr),
    .len_warn(len_warn), .fault(fault), .fault_code(fault_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference verdict, written from the requirement list
  function automatic int ref_code(input logic [31:0] ctrl, input logic [31:0] size,
                                  input logic [31:0] addr, input bit open);
    int  cnt;
    bit  begins;
    cnt    = int'(size >> 16);
    begins = (ctrl[1:0] == 2'b10) || (ctrl[1:0] == 2'b11);
    if (cnt == 0)                return 1;
    if (cnt > 65504)             return 2;
    if ((addr % 4) != 0)         return 3;
    if (begins == open)          return 4;
    return 0;
  endfunction

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_open = 1'b0; m_fault = 1'b0;
  endtask

  task automatic send_desc(input logic [31:0] ctrl, input logic [31:0] size,
                           input logic [31:0] addr, input string req);
    int code;
    code = ref_code(ctrl, size, addr, m_open);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (k == 0) ? ctrl : (k == 1) ? size : addr;
      @(posedge clk); #1;
    end
    chk(len_warn == (size[15:0] != 0), "R3", "len_warn", len_warn, size[15:0] != 0);
    if (code == 0) begin
      chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
      chk(out_start == ctrl[1] && out_end == ctrl[0], req, "start/end",
          {out_start, out_end}, ctrl[1:0]);
      chk(out_len == size[31:16], req, "out_len", out_len, size[31:16]);
      chk(out_addr == addr, req, "out_addr", out_addr, addr);
      chk(fault == 1'b0, req, "fault", fault, 0);
      m_open = !ctrl[0];
    end else begin
      chk(fault == 1'b1 && out_valid == 1'b0, req, "fault/out_valid",
          {fault, out_valid}, 2'b10);
      chk(int'(fault_code) == code, req, "fault_code", fault_code, code);
      m_fault = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(out_valid == 1'b0, "R11", "out_valid after pulse", out_valid, 0);
  endtask

  task automatic sticky_probe(input int exp_code);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 32'h0000_0002;
      @(posedge clk); #1;
      chk(in_ready == 1'b0 && out_valid == 1'b0 && fault == 1'b1, "R10",
          "ready/valid/fault", {in_ready, out_valid, fault}, 3'b001);
      chk(int'(fault_code) == exp_code, "R10", "fault_code held", fault_code, exp_code);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    do_reset();
    @(posedge clk); #1;
    chk(in_ready && !out_valid && !fault && !len_warn && fault_code == 0, "R1",
        "reset outputs", {in_ready, out_valid, fault, len_warn, fault_code}, 7'b1000000);

    // R2: single whole frame
    send_desc(32'h3, 32'h0040_0000, 32'h0000_1000, "R2");
    // R7: whole frame followed by a last-only descriptor
    send_desc(32'h1, 32'h0040_0000, 32'h0000_2000, "R7");
    sticky_probe(4);
    do_reset();
    @(posedge clk); #1;
    chk(!fault && in_ready, "R10", "reset clears fault", {fault, in_ready}, 2'b01);

    // R8: middle code first after reset
    send_desc(32'h0, 32'h0010_0000, 32'h0000_0100, "R8");
    do_reset();

    // R7: start, middle, last, then two starts in a row
    send_desc(32'h2, 32'h0100_0000, 32'h0000_0400, "R7");
    send_desc(32'h0, 32'h0100_0000, 32'h0000_0800, "R7");
    send_desc(32'h1, 32'h0100_0000, 32'h0000_0C00, "R7");
    send_desc(32'h2, 32'h0100_0000, 32'h0000_1000, "R7");
    send_desc(32'h2, 32'h0100_0000, 32'h0000_1400, "R7");
    do_reset();

    // R5: boundary count
    send_desc(32'h3, 32'hFFE0_0000, 32'h0000_4000, "R5");
    send_desc(32'h3, 32'hFFE1_0000, 32'h0000_4000, "R5");
    do_reset();

    // R4 and R9: zero count with misalignment and bad order reports zero
    send_desc(32'h0, 32'h0000_0000, 32'h0000_0003, "R4");
    do_reset();
    // R9: misaligned and bad order reports misalignment
    send_desc(32'h1, 32'h0020_0000, 32'h0000_0001, "R9");
    do_reset();
    // R6: misaligned only
    send_desc(32'h3, 32'h0020_0000, 32'h0000_1002, "R6");
    do_reset();

    // R3: reserved bits set on a legal descriptor
    send_desc(32'h3, 32'h0080_A5A5, 32'h0000_8000, "R3");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ctrl, size, addr;
      logic [15:0] cnt;
      int r;
      if (m_fault) do_reset();
      r = $urandom_range(99);
      if (r < 85) ctrl = m_open ? {31'd0, 1'($urandom_range(1))}
                               : {30'd0, 1'b1, 1'($urandom_range(1))};
      else        ctrl = {30'd0, 2'($urandom_range(3))};
      ctrl[31:2] = 30'($urandom);
      r = $urandom_range(99);
      if      (r < 5)  cnt = 16'd0;
      else if (r < 10) cnt = 16'($urandom_range(16'hFFFF, 16'hFFE1));
      else if (r < 14) cnt = 16'hFFE0;
      else             cnt = 16'($urandom_range(16'hFFE0, 1));
      size = {cnt, ($urandom_range(99) < 20) ? 16'($urandom) : 16'd0};
      addr = $urandom;
      if ($urandom_range(99) < 90) addr[1:0] = 2'b00;
      send_desc(ctrl, size, addr, "R2");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule